// File: doc/BRIEF.md
# Strobe-Order DRAM Refresh Scheduler

This block keeps an asynchronous DRAM refreshed without ever presenting a row address. A free-running interval timer marks the moment each refresh falls due. Every mark adds one to a count of owed refreshes. While that count is non-zero the block raises a request toward the access sequencer. When the sequencer has closed its open row, it answers with a grant. The scheduler then takes the strobes and runs one refresh cycle: all column strobes fall while the row strobe is still high, the row strobe follows them low, both return high together, and the row strobe then stays high for a precharge period. After that the block releases the bus and the owed count drops by one.

The timer period is a parameter in clock cycles. Its default comes from the clock period and a target just under 15.6 µs. That single target serves both a 2048-row part on a 32 ms window and a 4096-row part on a 64 ms window. The strobe phase lengths are rounded up from the minimum row-strobe low time, precharge time and cycle time. Refreshes that the sequencer postpones accumulate in the owed count. When that count reaches its ceiling, an urgent flag tells the sequencer to close its row at once.

Top module: `cbr_refresh_sched`

## Requirements
- R1: After reset is released, the owed count first increments on clock edge REFI_CYC+1 and then on every REFI_CYC-th edge after that, whether or not a grant is given.
- R2: A refresh starts only on an edge that samples ref_grant high while ref_req is high. On that edge ref_busy rises and all column strobes fall. A grant seen while nothing is owed is ignored, and the strobes stay high.
- R3: During a refresh, every cas_n lane carries the same value. The column strobes are low with ras_n high for exactly CAS_LEAD_CYC cycles (default 1) before ras_n falls.
- R4: ras_n stays low for exactly the rounded-up minimum row-strobe low time: 7 cycles at the default 8 ns clock for a 50 ns minimum. Column strobes stay low throughout, and ras_n and cas_n return high on the same edge.
- R5: After ras_n rises, ref_busy stays high with both strobes high for the precharge count: 4 cycles by default. That count is raised if needed so the whole refresh spans at least the minimum cycle time. ref_busy then falls.
- R6: we_n is high on every cycle.
- R7: The owed count drops by one on the edge where ref_busy falls. If a timer mark lands on that same edge, the count is unchanged.
- R8: The owed count saturates at 2^BACKLOG_W-1. ref_urgent is high exactly when the count equals that value.
- R9: ref_req is high exactly when the owed count is non-zero.
- R10: During and right after reset, ras_n, all cas_n lanes and we_n are high. ref_req, ref_busy and ref_urgent are low, and the owed count is zero.
- R11: If a grant is available on most cycles, every span of 8 timer intervals holds at least 7 completed refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Sequencer has closed its row and yields the strobes |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed count at its ceiling; sequencer must close its row |
| ref_busy | output | 1 | Scheduler owns the strobes |
| ref_owed | output | BACKLOG_W | Number of refreshes currently owed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes, active low, driven as one |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The bench models the timer marks from the cycle count alone. It tracks the expected owed count every cycle, so a timer that is off by one cycle, a counter that wraps instead of saturating, or a decrement that is lost when a mark coincides with a completion all show up as a count mismatch. It measures each phase of every refresh at the strobes. A design that raised the row strobe before the column strobes fell, cut the precharge short, or let one lane drift would give wrong phase widths. Long stretches with the grant held low push the count to its ceiling. Stretches with the grant held high check that no refresh starts while nothing is owed. A random-grant stretch then checks that the required number of refreshes still lands in every retention span.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_RASLO = 2'd2,
    ST_PRE   = 2'd3
  } cbr_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int REFI_CYC = 1875
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = $clog2(REFI_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/cbr_backlog.sv
module cbr_backlog #(
  parameter int BACKLOG_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 done_i,
  output logic [BACKLOG_W-1:0] owed_o,
  output logic                 req_o,
  output logic                 urgent_o
);
  localparam logic [BACKLOG_W-1:0] OWED_MAX = '1;

  logic [BACKLOG_W-1:0] owed_q, owed_nxt;
  logic                 req_q, urg_q;

  always_comb begin
    owed_nxt = owed_q;
    if (tick_i && !done_i) begin
      if (owed_q != OWED_MAX) owed_nxt = owed_q + 1'b1;
    end else if (done_i && !tick_i) begin
      if (owed_q != '0) owed_nxt = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
      req_q  <= 1'b0;
      urg_q  <= 1'b0;
    end else begin
      owed_q <= owed_nxt;
      req_q  <= (owed_nxt != '0);
      urg_q  <= (owed_nxt == OWED_MAX);
    end
  end

  assign owed_o   = owed_q;
  assign req_o    = req_q;
  assign urgent_o = urg_q;

  // R8
  owed_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (owed_q == OWED_MAX && !done_i) |=> owed_q == OWED_MAX);
  // R7
  owed_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !tick_i && owed_q != '0) |=> owed_q == $past(owed_q) - 1'b1);
  // R9
  req_match_chk: assert property (@(posedge clk) disable iff (rst)
    req_q == (owed_q != '0));
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import cbr_pkg::*;
#(
  parameter int CAS_LANES = 4,
  parameter int LEAD_CYC  = 1,
  parameter int LOW_CYC   = 7,
  parameter int PRE_CYC   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  output logic                 done_o,
  output logic                 busy_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o
);
  localparam int MAXC = (LOW_CYC > PRE_CYC) ? ((LOW_CYC > LEAD_CYC) ? LOW_CYC : LEAD_CYC)
                                            : ((PRE_CYC > LEAD_CYC) ? PRE_CYC : LEAD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  cbr_state_e     state_q, state_nxt;
  logic [CW-1:0]  cnt_q, cnt_nxt;
  logic           busy_q, ras_lo_q, cas_lo_q;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_nxt = ST_LEAD;
        cnt_nxt   = CW'(LEAD_CYC - 1);
      end
      ST_LEAD: if (cnt_q == '0) begin
        state_nxt = ST_RASLO;
        cnt_nxt   = CW'(LOW_CYC - 1);
      end else cnt_nxt = cnt_q - 1'b1;
      ST_RASLO: if (cnt_q == '0) begin
        state_nxt = ST_PRE;
        cnt_nxt   = CW'(PRE_CYC - 1);
      end else cnt_nxt = cnt_q - 1'b1;
      ST_PRE: if (cnt_q == '0) begin
        state_nxt = ST_IDLE;
        cnt_nxt   = '0;
      end else cnt_nxt = cnt_q - 1'b1;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      ras_lo_q <= 1'b0;
      cas_lo_q <= 1'b0;
    end else begin
      state_q  <= state_nxt;
      cnt_q    <= cnt_nxt;
      busy_q   <= (state_nxt != ST_IDLE);
      ras_lo_q <= (state_nxt == ST_RASLO);
      cas_lo_q <= (state_nxt == ST_LEAD) || (state_nxt == ST_RASLO);
    end
  end

  assign done_o  = (state_q == ST_PRE) && (cnt_q == '0);
  assign busy_o  = busy_q;
  assign ras_n_o = !ras_lo_q;
  assign cas_n_o = {CAS_LANES{!cas_lo_q}};

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> (cas_n_o == '0) && ($past(cas_n_o) == '0));
  // R4
  strobes_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o) |-> cas_n_o == '1);
  // R5
  ras_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ras_n_o |-> busy_o);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int REFI_TGT_NS   = 15000,
  parameter int REFI_CYC      = REFI_TGT_NS * 1000 / CLK_PERIOD_PS,
  parameter int T_RAS_PS      = 50000,
  parameter int T_RP_PS       = 30000,
  parameter int T_RC_PS       = 84000,
  parameter int CAS_LEAD_CYC  = 1,
  parameter int BACKLOG_W     = 3,
  parameter int CAS_LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_grant,
  output logic                 ref_req,
  output logic                 ref_urgent,
  output logic                 ref_busy,
  output logic [BACKLOG_W-1:0] ref_owed,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n,
  output logic                 we_n
);
  localparam int LOW_CYC = ceil_div(T_RAS_PS, CLK_PERIOD_PS);
  localparam int RP_CYC  = ceil_div(T_RP_PS, CLK_PERIOD_PS);
  localparam int RC_CYC  = ceil_div(T_RC_PS, CLK_PERIOD_PS);
  localparam int PRE_CYC = (RP_CYC > RC_CYC - CAS_LEAD_CYC - LOW_CYC)
                         ? RP_CYC : (RC_CYC - CAS_LEAD_CYC - LOW_CYC);

  logic tick, done, req;

  cbr_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  cbr_backlog #(.BACKLOG_W(BACKLOG_W)) u_backlog (
    .clk(clk), .rst(rst), .tick_i(tick), .done_i(done),
    .owed_o(ref_owed), .req_o(req), .urgent_o(ref_urgent)
  );

  cbr_strobe_fsm #(
    .CAS_LANES(CAS_LANES), .LEAD_CYC(CAS_LEAD_CYC),
    .LOW_CYC(LOW_CYC), .PRE_CYC(PRE_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(req && ref_grant), .done_o(done),
    .busy_o(ref_busy), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  assign ref_req = req;
  assign we_n    = 1'b1;

  // R2
  start_granted_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_busy) |-> $past(ref_grant) && $past(ref_req));
  // R2
  start_cas_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_busy) |-> cas_n == '0 && ras_n);
endmodule

// File: tb/sim_cbr_refresh_sched.sv
module sim_cbr_refresh_sched;
  localparam int REFI = 40;
  localparam int BW = 3;
  localparam int LANES = 4;
  localparam int OMAX = (1 << BW) - 1;
  localparam int LEAD_EXP = 1;
  localparam int LOW_EXP = (50000 + 7999) / 8000;
  localparam int PRE_EXP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_grant = 1'b0;
  logic ref_req, ref_urgent, ref_busy, ras_n, we_n;
  logic [BW-1:0] ref_owed;
  logic [LANES-1:0] cas_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_owed = 0;
  int refreshes = 0;
  int leadc = 0, lowc = 0, prec = 0;
  bit mon_on = 0;
  bit done_flag = 0;
  logic prev_busy = 1'b0, prev_ras = 1'b1, prev_grant = 1'b0;
  logic [LANES-1:0] prev_cas = '1;
  int prev_exp = 0;

  cbr_refresh_sched #(.REFI_CYC(REFI), .BACKLOG_W(BW), .CAS_LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .ref_grant(ref_grant), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_busy(ref_busy), .ref_owed(ref_owed),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic bit tick_at(input int e);
    return (e >= REFI + 1) && (((e - 1) % REFI) == 0);
  endfunction

  function automatic int next_owed(input int cur, input bit inc, input bit dec);
    if (inc && !dec) return (cur == OMAX) ? cur : cur + 1;
    if (dec && !inc) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  always @(negedge clk) begin
    if (!rst && mon_on) begin
      bit inc, dec;
      inc = tick_at(cyc);
      dec = prev_busy && !ref_busy;
      exp_owed = next_owed(exp_owed, inc, dec);
      // R1 R7 R8: owed count model
      chk(int'(ref_owed) == exp_owed, "R1/R7 owed count", int'(ref_owed), exp_owed);
      chk(ref_urgent == (exp_owed == OMAX), "R8 urgent", int'(ref_urgent), int'(exp_owed == OMAX));
      chk(ref_req == (exp_owed != 0), "R9 request", int'(ref_req), int'(exp_owed != 0));
      chk(we_n == 1'b1, "R6 write enable", int'(we_n), 1);
      chk(cas_n == '0 || cas_n == '1, "R3 lanes equal", int'(cas_n), 0);
      if (prev_cas == '1 && cas_n == '0) begin
        // R2: start only on granted, owed cycle
        chk(prev_grant && prev_exp != 0 && ref_busy && ras_n, "R2 start condition",
            int'({prev_grant, prev_exp != 0, ref_busy, ras_n}), 15);
      end
      if (!prev_ras && ras_n)
        chk(cas_n == '1, "R4 strobes rise together", int'(cas_n), int'({LANES{1'b1}}));
      if (ref_busy) begin
        if (cas_n == '0 && ras_n) leadc++;
        if (!ras_n) begin
          lowc++;
          chk(cas_n == '0, "R4 cas low under ras", int'(cas_n), 0);
        end
        if (cas_n == '1 && ras_n) prec++;
      end else begin
        chk(ras_n && cas_n == '1, "R5 strobes idle outside busy", int'(ras_n), 1);
      end
      if (dec) begin
        chk(leadc == LEAD_EXP, "R3 cas lead cycles", leadc, LEAD_EXP);
        chk(lowc == LOW_EXP, "R4 ras low cycles", lowc, LOW_EXP);
        chk(prec == PRE_EXP, "R5 precharge cycles", prec, PRE_EXP);
        refreshes++;
        leadc = 0; lowc = 0; prec = 0;
      end
    end
    prev_busy  = ref_busy;
    prev_ras   = ras_n;
    prev_cas   = cas_n;
    prev_grant = ref_grant;
    prev_exp   = exp_owed;
  end

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic set_grant(input logic g);
    @(posedge clk);
    #1 ref_grant = g;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int seed_v;
    int base;
    seed_v = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(ras_n && cas_n == '1 && we_n, "R10 strobes in reset", int'(ras_n), 1);
    chk(!ref_req && !ref_busy && !ref_urgent, "R10 flags in reset",
        int'({ref_req, ref_busy, ref_urgent}), 0);
    chk(ref_owed == '0, "R10 owed in reset", int'(ref_owed), 0);
    @(posedge clk);
    #1 rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    chk(ras_n && !ref_busy && ref_owed == '0, "R10 state after reset", int'(ref_owed), 0);

    // Grant withheld: backlog saturates, no refresh runs (R2, R8)
    repeat (9 * REFI) @(posedge clk);
    @(negedge clk);
    chk(int'(ref_owed) == OMAX, "R8 saturation", int'(ref_owed), OMAX);
    chk(ref_urgent, "R8 urgent at ceiling", int'(ref_urgent), 1);
    chk(refreshes == 0, "R2 no refresh without grant", refreshes, 0);

    // Grant held high: backlog drains, idle grant ignored
    set_grant(1'b1);
    repeat (10 * REFI) @(posedge clk);
    @(negedge clk);
    chk(!ref_urgent && ref_owed <= 1, "R7 backlog drained", int'(ref_owed), 0);

    // Random grant: retention window (R11)
    for (int w = 0; w < 5; w++) begin
      base = refreshes;
      for (int i = 0; i < 8 * REFI; i++) begin
        @(posedge clk);
        #1 ref_grant = (($urandom % 4) != 0);
      end
      chk(refreshes - base >= 7, "R11 refreshes per window", refreshes - base, 7);
    end

    set_grant(1'b1);
    repeat (3 * REFI) @(posedge clk);
    @(negedge clk);
    chk(ref_owed <= 1 && !ref_urgent, "R9 steady state backlog", int'(ref_owed), 0);
    finish_up();
  end
endmodule